// File: doc/BRIEF.md
# Serial Configuration Register Write Port

This block is a write-only three-wire serial slave that loads a small bank of 8-bit configuration registers. The serial clock, data and active-low select come in asynchronously. They are resynchronised into the system clock domain, and the data is assembled one byte at a time, most significant bit first. Each bit is taken on a rising edge of the serial clock.

A transaction opens when select falls. The first byte carries the register address in its low six bits. The second byte is discarded. Every byte after that is data: the first data byte goes to the addressed register, and each further data byte goes to the next address for as long as select stays low.

The bank drives decoded configuration fields straight to the datapath it controls:
- power-up enable
- attenuation tracking
- soft mute and bypass, each ORed with an external pin
- port mode
- two filter options
- input format, output format and output word length
- left and right attenuation in half-dB steps

Every register clears on reset, so the datapath starts powered down.

Top module: `spi_cfg_port`

## Requirements
- R1: While rst_ni is low, and after reset until the first write, every output field is 0 (pdn_o = 0 means powered down). mute_o and bypass_o are the exceptions: they follow mute_i and bypass_i.
- R2: A transaction is: select low, an address byte (its low 6 bits are the address and its top 2 bits are ignored), a discarded byte, then a data byte. It loads register 1 as follows: bit 7 to pdn_o, bit 6 to track_o, bit 4 to the mute bit, bit 3 to the bypass bit, and bits 2:0 to port_mode_o.
- R3: The second byte of a transaction never writes any register, whatever its value. A transaction of only two bytes changes nothing.
- R4: While select stays low, each further data byte goes to the previous address plus 1, modulo 64. Auto-increment is always on.
- R5: Register 2 bit 1 drives direct_down_o and bit 0 drives low_delay_o. Register 3 bits 7:6 drive out_len_o, bits 5:4 drive out_fmt_o and bits 2:0 drive in_fmt_o.
- R6: Register 4 drives atten_l_o and register 5 drives atten_r_o, all 8 bits each. The attenuation is the code times 0.5 dB.
- R7: A data byte addressed to register 0 or to addresses 6 to 63 changes no output.
- R8: Reserved bit positions never change anything: register 1 bit 5, register 2 bits 7:2 and register 3 bit 3.
- R9: A byte left incomplete when select rises is discarded. The next transaction starts again with an address byte.
- R10: mute_o is the mute bit of register 1 ORed with mute_i, and bypass_o is the bypass bit ORed with bypass_i.
- R11: The register write lands on the 3rd rising edge of clk_i after the serial clock edge that carries the last bit of a data byte. Register values hold when no write occurs, including while pdn_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data, MSB first |
| csn_i | input | 1 | Active-low select |
| mute_i | input | 1 | External mute request |
| bypass_i | input | 1 | External bypass request |
| pdn_o | output | 1 | 1 = powered up, 0 = power-down |
| track_o | output | 1 | Right attenuation tracks left |
| mute_o | output | 1 | Effective soft mute |
| bypass_o | output | 1 | Effective bypass |
| port_mode_o | output | 3 | Serial port master/slave mode |
| direct_down_o | output | 1 | Direct down-sampling select |
| low_delay_o | output | 1 | Low group delay select |
| out_len_o | output | 2 | Output word length code |
| out_fmt_o | output | 2 | Output data format code |
| in_fmt_o | output | 3 | Input data format code |
| atten_l_o | output | 8 | Left attenuation code |
| atten_r_o | output | 8 | Right attenuation code |

## Verification
The serial inputs go through two synchroniser flops and an edge register, so a register update appears on the third clk_i rising edge after the serial clock rises with a byte's last bit. The bench checks this directly: after that serial edge it samples the output at the falling clock edge following the second rising edge and expects the old value, then samples after the third rising edge and expects the new value. All other checks wait until select has been high for several cycles, so every write has settled. The serial clock runs at eight system clocks per bit, which keeps each sample well clear of the write edge.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 6;
  localparam int NREG   = 6;

  typedef enum logic [1:0] {PH_ADDR, PH_SKIP, PH_DATA} phase_e;

  // writable bits per register; reserved positions stay zero
  function automatic logic [BYTE_W-1:0] wmask(input int unsigned a);
    case (a)
      1:       return 8'hDF;
      2:       return 8'h03;
      3:       return 8'hF7;
      4, 5:    return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st[s] <= RST_VAL;
      else if (s == 0) st[s] <= d_i;
      else st[s] <= st[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/spi_byte_rx.sv
module spi_byte_rx
  import spi_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              cs_act_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic              sclk_q;
  logic              rise;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] sh;
  logic [BYTE_W-1:0] nxt;
  logic              last_bit;
  phase_e            phase;
  logic [ADDR_W-1:0] addr;

  assign rise     = sclk_i & ~sclk_q;
  assign nxt      = {sh, sdi_i};
  assign last_bit = (bit_cnt == CNT_W'(BYTE_W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt <= '0;
      sh      <= '0;
      phase   <= PH_ADDR;
      addr    <= '0;
    end else if (!cs_act_i) begin
      bit_cnt <= '0;  // partial byte dropped
      phase   <= PH_ADDR;
    end else if (rise) begin
      sh      <= nxt[BYTE_W-2:0];
      bit_cnt <= bit_cnt + 1'b1;
      if (last_bit) begin
        case (phase)
          PH_ADDR: begin
            addr  <= nxt[ADDR_W-1:0];
            phase <= PH_SKIP;
          end
          PH_SKIP: phase <= PH_DATA;
          default: addr  <= addr + 1'b1;
        endcase
      end
    end
  end

  assign wr_en_o   = rise & cs_act_i & last_bit & (phase == PH_DATA);
  assign wr_addr_o = addr;
  assign wr_data_o = nxt;
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import spi_cfg_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           wr_addr_i,
  input  logic [BYTE_W-1:0]           wr_data_i,
  output logic [NREG-1:0][BYTE_W-1:0] regs_o
);
  assign regs_o[0] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(i)) q <= wr_data_i & wmask(i);
    end
    assign regs_o[i] = q;
  end
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
  import spi_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       sdi_i,
  input  logic       csn_i,
  input  logic       mute_i,
  input  logic       bypass_i,
  output logic       pdn_o,
  output logic       track_o,
  output logic       mute_o,
  output logic       bypass_o,
  output logic [2:0] port_mode_o,
  output logic       direct_down_o,
  output logic       low_delay_o,
  output logic [1:0] out_len_o,
  output logic [1:0] out_fmt_o,
  output logic [2:0] in_fmt_o,
  output logic [7:0] atten_l_o,
  output logic [7:0] atten_r_o
);
  logic [2:0]                  sync_q;
  logic                        cs_act;
  logic                        wr_en;
  logic [ADDR_W-1:0]           wr_addr;
  logic [BYTE_W-1:0]           wr_data;
  logic [NREG-1:0][BYTE_W-1:0] regs;
  logic                        unused;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({csn_i, sdi_i, sclk_i}),
    .q_o   (sync_q)
  );

  assign cs_act = ~sync_q[2];

  spi_byte_rx u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_i   (sync_q[0]),
    .sdi_i    (sync_q[1]),
    .cs_act_i (cs_act),
    .wr_en_o  (wr_en),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data)
  );

  cfg_bank u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .regs_o   (regs)
  );

  assign pdn_o         = regs[1][7];
  assign track_o       = regs[1][6];
  assign mute_o        = regs[1][4] | mute_i;
  assign bypass_o      = regs[1][3] | bypass_i;
  assign port_mode_o   = regs[1][2:0];
  assign direct_down_o = regs[2][1];
  assign low_delay_o   = regs[2][0];
  assign out_len_o     = regs[3][7:6];
  assign out_fmt_o     = regs[3][5:4];
  assign in_fmt_o      = regs[3][2:0];
  assign atten_l_o     = regs[4];
  assign atten_r_o     = regs[5];

  assign unused = ^{regs[0], regs[1][5], regs[2][7:2], regs[3][3]};
endmodule

// File: rtl/spi_cfg_port_chk.sv
module spi_cfg_port_chk
  import spi_cfg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_act,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              pdn_o,
  input logic              track_o,
  input logic [2:0]        port_mode_o,
  input logic              direct_down_o,
  input logic              low_delay_o,
  input logic [1:0]        out_len_o,
  input logic [1:0]        out_fmt_o,
  input logic [2:0]        in_fmt_o,
  input logic [7:0]        atten_l_o,
  input logic [7:0]        atten_r_o
);
  logic [30:0] all_f;
  assign all_f = {pdn_o, track_o, port_mode_o, direct_down_o, low_delay_o,
                  out_len_o, out_fmt_o, in_fmt_o, atten_l_o, atten_r_o};

  always @(posedge clk_i)
    if (!rst_ni) a_r1_reset_clear: assert (all_f == '0);

  a_r7_reserved_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en && (wr_addr == '0 || wr_addr >= ADDR_W'(NREG)) |=> $stable(all_f));

  a_r4_addr_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> wr_addr == $past(wr_addr) + 1'b1);

  a_r11_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act |=> $stable(all_f));

  a_r8_one_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en && wr_addr == ADDR_W'(2) |=>
      $stable({pdn_o, track_o, port_mode_o, atten_l_o, atten_r_o, out_len_o, out_fmt_o, in_fmt_o}));
endmodule

bind spi_cfg_port spi_cfg_port_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_act       (cs_act),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .pdn_o        (pdn_o),
  .track_o      (track_o),
  .port_mode_o  (port_mode_o),
  .direct_down_o(direct_down_o),
  .low_delay_o  (low_delay_o),
  .out_len_o    (out_len_o),
  .out_fmt_o    (out_fmt_o),
  .in_fmt_o     (in_fmt_o),
  .atten_l_o    (atten_l_o),
  .atten_r_o    (atten_r_o)
);

// File: tb/sim_spi_cfg_port.sv
module sim_spi_cfg_port;
  logic clk = 0, rst_ni = 0;
  logic sclk = 0, sdi = 0, csn = 1, mute = 0, byp = 0;
  logic pdn, track, mute_o, byp_o, dd, ld;
  logic [2:0] mode, ifmt;
  logic [1:0] olen, ofmt;
  logic [7:0] al, ar;
  int total = 0, bad = 0;
  logic [7:0] exp_r [0:5];
  logic [7:0] tx [0:7];

  always #2 clk = ~clk;

  spi_cfg_port u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdi_i(sdi), .csn_i(csn),
    .mute_i(mute), .bypass_i(byp), .pdn_o(pdn), .track_o(track),
    .mute_o(mute_o), .bypass_o(byp_o), .port_mode_o(mode),
    .direct_down_o(dd), .low_delay_o(ld), .out_len_o(olen),
    .out_fmt_o(ofmt), .in_fmt_o(ifmt), .atten_l_o(al), .atten_r_o(ar)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, expv, $time);
    end
  endtask

  function automatic logic [7:0] msk(input int a);
    case (a)
      1: return 8'hDF; 2: return 8'h03; 3: return 8'hF7;
      4, 5: return 8'hFF; default: return 8'h00;
    endcase
  endfunction

  task automatic check_all(input string ctx);
    chk({ctx, " R2 pdn"},   {7'd0, pdn},   {7'd0, exp_r[1][7]});
    chk({ctx, " R2 track"}, {7'd0, track}, {7'd0, exp_r[1][6]});
    chk({ctx, " R2 mode"},  {5'd0, mode},  {5'd0, exp_r[1][2:0]});
    chk({ctx, " R10 mute"}, {7'd0, mute_o}, {7'd0, exp_r[1][4] | mute});
    chk({ctx, " R10 byp"},  {7'd0, byp_o},  {7'd0, exp_r[1][3] | byp});
    chk({ctx, " R5 r2"},    {6'd0, dd, ld}, {6'd0, exp_r[2][1:0]});
    chk({ctx, " R5 r3"},    {olen, ofmt, 1'b0, ifmt}, exp_r[3]);
    chk({ctx, " R6 left"},  al, exp_r[4]);
    chk({ctx, " R6 right"}, ar, exp_r[5]);
  endtask

  task automatic sbyte(input logic [7:0] b, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      sdi = b[7-i];
      repeat (4) @(negedge clk);
      sclk = 1;
      repeat (4) @(negedge clk);
      sclk = 0;
    end
  endtask

  // n bytes from tx, last one truncated to last_bits
  task automatic xfer(input int n, input int last_bits);
    csn = 0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < n; k++) sbyte(tx[k], (k == n-1) ? last_bits : 8);
    repeat (4) @(negedge clk);
    csn = 1;
    repeat (8) @(negedge clk);
    for (int k = 2; k < n; k++) begin
      if (k < n-1 || last_bits == 8) begin
        int a;
        a = (int'(tx[0][5:0]) + k - 2) % 64;
        if (a >= 1 && a <= 5) exp_r[a] = tx[k] & msk(a);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) exp_r[i] = 8'h00;
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_ni = 1;
    repeat (3) @(negedge clk);
    check_all("R1 after reset");

    // R10 pins alone
    mute = 1; byp = 1; @(negedge clk);
    check_all("R10 pins");
    mute = 0; byp = 0;

    // R2 R3 R5 R6 R7 R8 sweep: address v%8 (0,6,7 reserved), dummy byte ~v
    for (int v = 0; v < 256; v++) begin
      tx[0] = {2'b00, 3'd0, 3'(v % 8)}; tx[1] = ~8'(v); tx[2] = 8'(v);
      xfer(3, 8);
      check_all("sweep");
    end

    // R2: top address bits ignored
    tx[0] = 8'hC4; tx[1] = 8'h05; tx[2] = 8'h3C;
    xfer(3, 8);
    check_all("R2 addr top bits");

    // R3: two-byte transaction writes nothing
    tx[0] = 8'h01; tx[1] = 8'hFF;
    xfer(2, 8);
    check_all("R3 two bytes");

    // R4 burst 1..5
    tx[0] = 8'h01; tx[1] = 8'h00;
    tx[2] = 8'hD5; tx[3] = 8'hFF; tx[4] = 8'hFF; tx[5] = 8'h11; tx[6] = 8'h22;
    xfer(7, 8);
    check_all("R4 burst");
    chk("R4 burst left", al, 8'h11);
    chk("R4 burst right", ar, 8'h22);

    // R4 R7 wrap 62,63,0,1,2
    tx[0] = 8'h3E; tx[1] = 8'h00;
    tx[2] = 8'hAA; tx[3] = 8'hBB; tx[4] = 8'hCC; tx[5] = 8'h5A; tx[6] = 8'h02;
    xfer(7, 8);
    check_all("R4 wrap");
    chk("R4 wrap reg1", {pdn, track, 1'b0, mute_o, byp_o, mode}, 8'h5A & 8'hDF);

    // R7 burst from 5 into 6
    tx[0] = 8'h05; tx[1] = 8'h00; tx[2] = 8'h77; tx[3] = 8'h99;
    xfer(4, 8);
    check_all("R7 past 5");

    // R9 partial data byte dropped
    tx[0] = 8'h04; tx[1] = 8'h00; tx[2] = 8'hF0;
    xfer(3, 5);
    check_all("R9 partial data");
    // R9 partial address byte then fresh transaction
    tx[0] = 8'hFF;
    xfer(1, 3);
    tx[0] = 8'h05; tx[1] = 8'h04; tx[2] = 8'h81;
    xfer(3, 8);
    check_all("R9 after partial");
    chk("R9 right", ar, 8'h81);

    // R10 reg bits with pins low, then both
    tx[0] = 8'h01; tx[1] = 8'h00; tx[2] = 8'h18;
    xfer(3, 8);
    check_all("R10 reg");
    mute = 1; byp = 1; @(negedge clk);
    check_all("R10 both");
    mute = 0; byp = 0;

    // R11 latency on the last bit of a data byte to register 4
    csn = 0;
    repeat (4) @(negedge clk);
    sbyte(8'h04, 8); sbyte(8'h00, 8); sbyte(8'hA5, 7);
    sdi = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R11 before edge3", al, exp_r[4]);
    @(posedge clk); @(negedge clk);
    chk("R11 at edge3", al, 8'hA5);
    exp_r[4] = 8'hA5;
    repeat (2) @(negedge clk);
    sclk = 0;
    repeat (4) @(negedge clk);
    csn = 1;
    repeat (8) @(negedge clk);
    check_all("R11 hold");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule